// File: doc/BRIEF.md
# Multi-Rate Frequency Step Detector

This block watches one clock channel for sudden frequency changes. Once per second it receives a signed frequency-difference sample. It feeds that sample into a bank of first-order exponential averagers whose time constants grow from one filter to the next. Subtracting each filter from its slower neighbour gives a band-limited signal. A fast pair reacts within a few samples to a large step. A slow pair only builds up enough difference after many samples, but it can resolve a much smaller step.

Each adjacent pair drives one detector. The detector compares the magnitude of its difference against an unsigned threshold of its own. A trip sets a sticky alarm bit and raises a one-cycle pulse. The pulse carries the index of the fastest detector that newly tripped and the signed difference it saw, which serves as the step estimate for whatever correction logic sits downstream.

A clear command drops all alarms and arms a reload. The next sample is then written into every filter directly, so the step that has just been handled does not trip the detectors a second time.

Top module: `fjd_top`

## Requirements
- R1: On each clock edge with `smp_valid` high and no reload pending, filter i (i = 0 is the fastest) takes y + ((x·2^FRAC_W − y) >>> k_i), where k_i = SHIFT_BASE + i·SHIFT_STEP. The new value is visible on `filt_state[i*ST_W +: ST_W]` in the following cycle. Without a strobe, every filter holds its value.
- R2: After reset, and after any `clr`, the next strobe loads every filter with x·2^FRAC_W instead of filtering. A strobe in the same cycle as `clr` is such a loading strobe.
- R3: Detector j trips when |y_j − y_(j+1)| is strictly greater than the unsigned threshold `thresh[j*THR_W +: THR_W]`. Detectors are evaluated only in the cycle after a filtering update. Loading updates are never evaluated.
- R4: `alarm[j]` stays set until `clr`. A `clr` clears all alarm bits at the next edge and takes precedence over a trip evaluated at the same edge.
- R5: `trip_pulse` is high for one cycle when at least one detector that was not already alarmed trips. `trip_idx` gives the lowest such index.
- R6: At each pulse, `step_est` takes the signed difference y_j − y_(j+1) of the detector named by `trip_idx`, in filter-state units. It holds that value until the next pulse.
- R7: During reset, all filter states, alarms, `trip_pulse`, `trip_idx` and `step_est` are zero, and a reload is armed.
- R8: A constant input after a load never trips any detector.
- R9: With thresholds that decrease from the fastest pair to the slowest, a large step trips detector 0 after fewer samples than a small step needs to trip the slowest detector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, to be deasserted synchronously to clk |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Signed frequency-difference sample |
| thresh | input | ND*THR_W | Unsigned per-detector thresholds, detector j at [j*THR_W +: THR_W] |
| clr | input | 1 | Clear alarms and arm a filter reload |
| alarm | output | ND | Sticky alarm bit per detector |
| trip_pulse | output | 1 | One-cycle pulse on a new trip |
| trip_idx | output | IDX_W | Lowest newly tripped detector |
| step_est | output | ST_W+1 | Signed step estimate captured at the pulse |
| filt_state | output | NUM_FILT*ST_W | Filter states, filter i at [i*ST_W +: ST_W] |

## Verification
The hardest situation to reach is a small step that slips past the fast detectors and trips only the slowest pair. It takes many samples to build up, and any clear or reload on the way resets the build-up. The stimulus sets thresholds that fall from the fastest pair to the slowest. It applies a small step and keeps feeding it, counting samples until the pulse. It then compares that count and the reported index with those of a large step.

The strict threshold boundary is reached by loading zero and then applying a single unit sample. This gives an exactly known difference on detector 0, and the threshold is set to that difference and then to one less. A behavioural model compares the filter states, alarms, pulse, index and estimate on every clock.

// File: rtl/fjd_pkg.sv
package fjd_pkg;
  // Right-shift amount (log2 of the filtering factor) of filter idx
  function automatic int filt_shift(input int base, input int step, input int idx);
    return base + step * idx;
  endfunction
endpackage

// File: rtl/fjd_ema_stage.sv
module fjd_ema_stage #(
  parameter int SAMPLE_W = 16,
  parameter int FRAC_W   = 8,
  parameter int ST_W     = SAMPLE_W + FRAC_W,
  parameter int SHIFT    = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic                reload,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic [ST_W-1:0]     state_o
);
  logic signed [ST_W:0]   target;
  logic signed [ST_W:0]   cur;
  logic signed [ST_W:0]   delta;
  logic signed [ST_W:0]   incr;
  logic signed [ST_W:0]   sum;
  logic        [ST_W-1:0] state_d;
  logic        [ST_W-1:0] state_q;

  always_comb begin
    target  = $signed({smp_data[SAMPLE_W-1], smp_data, {FRAC_W{1'b0}}});
    cur     = $signed({state_q[ST_W-1], state_q});
    delta   = target - cur;
    incr    = delta >>> SHIFT;
    sum     = cur + incr;
    state_d = reload ? target[ST_W-1:0] : sum[ST_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         state_q <= '0;
    else if (smp_valid) state_q <= state_d;
  end

  assign state_o = state_q;

  // R1
  hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(state_q));

  // R2
  load_takes_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && reload) |=> (state_q == $past({smp_data, {FRAC_W{1'b0}}})));
endmodule

// File: rtl/fjd_pair_cmp.sv
module fjd_pair_cmp #(
  parameter int ST_W  = 24,
  parameter int THR_W = 24
) (
  input  logic [ST_W-1:0]  fast_i,
  input  logic [ST_W-1:0]  slow_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             trip_o,
  output logic [ST_W:0]    diff_o
);
  localparam int PAD_W = ST_W + 1 - THR_W;

  logic signed [ST_W:0] diff;
  logic        [ST_W:0] mag;
  logic        [ST_W:0] thr_ext;

  always_comb begin
    diff    = $signed({fast_i[ST_W-1], fast_i}) - $signed({slow_i[ST_W-1], slow_i});
    mag     = diff[ST_W] ? (-diff) : diff;
    thr_ext = {{PAD_W{1'b0}}, thr_i};
    trip_o  = (mag > thr_ext);
    diff_o  = diff;
  end
endmodule

// File: rtl/fjd_alarm_ctl.sv
module fjd_alarm_ctl #(
  parameter int ND    = 3,
  parameter int ST_W  = 24,
  parameter int IDX_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     eval,
  input  logic [ND-1:0]            trip,
  input  logic [ND-1:0][ST_W:0]    diff,
  output logic [ND-1:0]            alarm,
  output logic                     pulse,
  output logic [IDX_W-1:0]         idx,
  output logic [ST_W:0]            est
);
  logic [ND-1:0]    alarm_q, alarm_d, newhit;
  logic             pulse_q, pulse_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [ST_W:0]    est_q, est_d;

  always_comb begin
    newhit  = trip & ~alarm_q & {ND{eval}};
    alarm_d = clr ? '0 : (alarm_q | newhit);
    pulse_d = !clr && (|newhit);
    idx_d   = idx_q;
    est_d   = est_q;
    if (pulse_d) begin
      for (int j = ND - 1; j >= 0; j--) begin
        if (newhit[j]) begin
          idx_d = IDX_W'(j);
          est_d = diff[j];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q <= '0;
      pulse_q <= 1'b0;
      idx_q   <= '0;
      est_q   <= '0;
    end else begin
      alarm_q <= alarm_d;
      pulse_q <= pulse_d;
      idx_q   <= idx_d;
      est_q   <= est_d;
    end
  end

  assign alarm = alarm_q;
  assign pulse = pulse_q;
  assign idx   = idx_q;
  assign est   = est_q;

  // R4
  clear_drops_alarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (alarm_q == '0));

  // R4
  alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((alarm_q & $past(alarm_q)) == $past(alarm_q)));

  // R5
  pulse_marks_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> alarm_q[idx_q]);

  // R6
  est_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_d |=> $stable(est_q));
endmodule

// File: rtl/fjd_top.sv
module fjd_top #(
  parameter int NUM_FILT   = 4,
  parameter int SAMPLE_W   = 16,
  parameter int FRAC_W     = 8,
  parameter int THR_W      = 24,
  parameter int SHIFT_BASE = 1,
  parameter int SHIFT_STEP = 2,
  localparam int ST_W      = SAMPLE_W + FRAC_W,
  localparam int ND        = NUM_FILT - 1,
  localparam int IDX_W     = (ND > 1) ? $clog2(ND) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic [SAMPLE_W-1:0]      smp_data,
  input  logic [ND*THR_W-1:0]      thresh,
  input  logic                     clr,
  output logic [ND-1:0]            alarm,
  output logic                     trip_pulse,
  output logic [IDX_W-1:0]         trip_idx,
  output logic [ST_W:0]            step_est,
  output logic [NUM_FILT*ST_W-1:0] filt_state
);
  logic                 reload_q, reload_d, reload_eff;
  logic                 eval_q, eval_d;
  logic [ST_W-1:0]      st [NUM_FILT];
  logic [ND-1:0]        trip;
  logic [ND-1:0][ST_W:0] diff;

  always_comb begin
    reload_eff = reload_q | clr;
    reload_d   = smp_valid ? 1'b0 : reload_eff;
    eval_d     = smp_valid & ~reload_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= 1'b1;
      eval_q   <= 1'b0;
    end else begin
      reload_q <= reload_d;
      eval_q   <= eval_d;
    end
  end

  for (genvar i = 0; i < NUM_FILT; i++) begin : g_filt
    localparam int SH = fjd_pkg::filt_shift(SHIFT_BASE, SHIFT_STEP, i);
    fjd_ema_stage #(
      .SAMPLE_W(SAMPLE_W), .FRAC_W(FRAC_W), .ST_W(ST_W), .SHIFT(SH)
    ) u_ema (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .reload(reload_eff),
      .smp_data(smp_data), .state_o(st[i])
    );
    assign filt_state[i*ST_W +: ST_W] = st[i];
  end

  for (genvar j = 0; j < ND; j++) begin : g_det
    fjd_pair_cmp #(.ST_W(ST_W), .THR_W(THR_W)) u_cmp (
      .fast_i(st[j]), .slow_i(st[j+1]), .thr_i(thresh[j*THR_W +: THR_W]),
      .trip_o(trip[j]), .diff_o(diff[j])
    );
  end

  fjd_alarm_ctl #(.ND(ND), .ST_W(ST_W), .IDX_W(IDX_W)) u_alarm (
    .clk(clk), .rst_n(rst_n), .clr(clr), .eval(eval_q), .trip(trip), .diff(diff),
    .alarm(alarm), .pulse(trip_pulse), .idx(trip_idx), .est(step_est)
  );

  // R2
  reload_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !reload_q);

  // R3
  no_eval_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && reload_eff) |=> !eval_q);
endmodule

// File: tb/fjd_top_test.sv
module fjd_top_test;
  localparam int NF = 4;
  localparam int ND = 3;
  localparam int SW = 16;
  localparam int FW = 8;
  localparam int ST = SW + FW;
  localparam int TW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic clr = 1'b0;
  int   xin = 0;
  logic [TW-1:0] thr [ND];

  logic [ND*TW-1:0] thresh;
  logic [ND-1:0]    alarm;
  logic             trip_pulse;
  logic [1:0]       trip_idx;
  logic [ST:0]      step_est;
  logic [NF*ST-1:0] filt_state;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  always_comb for (int j = 0; j < ND; j++) thresh[j*TW +: TW] = thr[j];

  fjd_top uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(xin[SW-1:0]),
    .thresh(thresh), .clr(clr), .alarm(alarm), .trip_pulse(trip_pulse),
    .trip_idx(trip_idx), .step_est(step_est), .filt_state(filt_state)
  );

  // behavioural reference
  longint m_y [NF];
  bit     m_alarm [ND];
  bit     m_pulse, m_reload, m_upd;
  int     m_idx;
  longint m_est;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NF; i++) m_y[i] = 0;
      for (int j = 0; j < ND; j++) m_alarm[j] = 0;
      m_pulse = 0; m_reload = 1; m_upd = 0; m_idx = 0; m_est = 0;
    end else begin
      bit any;
      bit rl;
      longint xt;
      any = 0;
      for (int j = 0; j < ND; j++) begin
        longint d, a;
        d = m_y[j] - m_y[j+1];
        a = (d < 0) ? -d : d;
        if (m_upd && !m_alarm[j] && a > longint'(thr[j]) && !clr) begin
          if (!any) begin m_idx = j; m_est = d; end
          any = 1;
          m_alarm[j] = 1;
        end
      end
      if (clr) for (int j = 0; j < ND; j++) m_alarm[j] = 0;
      m_pulse = any;
      rl = m_reload || clr;
      xt = longint'(xin) * 256;
      if (smp_valid)
        for (int i = 0; i < NF; i++)
          m_y[i] = rl ? xt : m_y[i] + ((xt - m_y[i]) >>> (1 + 2 * i));
      m_upd = smp_valid && !rl;
      m_reload = smp_valid ? 0 : rl;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // cycle compare on falling edges
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NF; i++) begin
        longint a;
        a = longint'($signed(filt_state[i*ST +: ST]));
        chk(a == m_y[i], "R1 filter state", a, m_y[i]);
      end
      for (int j = 0; j < ND; j++)
        chk(alarm[j] == m_alarm[j], "R4 alarm bit", alarm[j], m_alarm[j]);
      chk(trip_pulse == m_pulse, "R5 pulse", trip_pulse, m_pulse);
      chk(int'(trip_idx) == m_idx, "R5 index", trip_idx, m_idx);
      chk(longint'($signed(step_est)) == m_est, "R6 estimate", $signed(step_est), m_est);
    end
  end

  task automatic tick(input bit v, input int x, input bit c);
    @(negedge clk);
    smp_valid = v; xin = x; clr = c;
  endtask

  task automatic look;
    @(posedge clk); #1;
  endtask

  // feed x once per two cycles until a pulse; returns number of samples
  task automatic run_until_trip(input int x, input int limit, output int n);
    n = 0;
    for (int k = 1; k <= limit; k++) begin
      tick(1, x, 0); tick(0, x, 0); look();
      if (trip_pulse) begin n = k; break; end
    end
  endtask

  int n_big, n_small;

  initial begin
    thr[0] = 24'd40000; thr[1] = 24'd10000; thr[2] = 24'd1000;
    #23; rst_n = 1'b1;
    #1;
    // R7 reset state
    chk(filt_state == '0, "R7 states zero", filt_state, 0);
    chk(alarm == '0 && !trip_pulse && trip_idx == 0 && step_est == '0, "R7 outputs zero", alarm, 0);

    // R2 first sample loads all filters
    tick(1, 5000, 0); tick(0, 5000, 0); look();
    for (int i = 0; i < NF; i++)
      chk($signed(filt_state[i*ST +: ST]) == 5000 * 256, "R2 load after reset",
          $signed(filt_state[i*ST +: ST]), 5000 * 256);
    chk(alarm == '0, "R2 no trip on load", alarm, 0);

    // R8 constant input
    for (int k = 0; k < 20; k++) tick(1, 5000, 0);
    tick(0, 5000, 0); look();
    chk(alarm == '0, "R8 constant no trip", alarm, 0);

    // R3 R5 R9 large step trips detector 0
    run_until_trip(6000, 40, n_big);
    chk(n_big > 0 && trip_idx == 0, "R9 large step on detector 0", trip_idx, 0);
    chk($signed(step_est) > 0, "R6 positive estimate", $signed(step_est), 1);
    for (int k = 0; k < 5; k++) tick(1, 6000, 0);
    tick(0, 6000, 0); look();
    chk(alarm[0] == 1'b1, "R4 sticky alarm", alarm[0], 1);

    // R4 clear without sample, then R2 reload on next sample
    tick(0, 6000, 1); tick(0, 6000, 0); look();
    chk(alarm == '0, "R4 cleared", alarm, 0);
    tick(1, 6000, 0); tick(0, 6000, 0); look();
    chk($signed(filt_state[3*ST +: ST]) == 6000 * 256, "R2 reload after clear",
        $signed(filt_state[3*ST +: ST]), 6000 * 256);
    for (int k = 0; k < 10; k++) tick(1, 6000, 0);
    tick(0, 6000, 0); look();
    chk(alarm == '0, "R2 no retrigger after reload", alarm, 0);

    // R9 small step trips only the slowest pair, later
    run_until_trip(6016, 200, n_small);
    chk(n_small > 0 && trip_idx == 2, "R9 small step on detector 2", trip_idx, 2);
    chk(n_small > n_big, "R9 small step slower", n_small, n_big);

    // R2 clear together with a sample reloads on that sample
    tick(1, -3000, 1); tick(0, -3000, 0); look();
    chk($signed(filt_state[0 +: ST]) == -3000 * 256 && alarm == '0, "R2 clear with sample",
        $signed(filt_state[0 +: ST]), -3000 * 256);

    // R3 negative step uses magnitude
    run_until_trip(-4000, 40, n_big);
    chk(n_big > 0 && trip_idx == 0 && $signed(step_est) < 0, "R3 negative step", $signed(step_est), -1);

    // R3 strict comparison at the boundary: diff after unit sample is 128-32 = 96
    thr[0] = 24'd96; thr[1] = 24'hFFFFFF; thr[2] = 24'hFFFFFF;
    tick(1, 0, 1); tick(1, 1, 0); tick(0, 1, 0); look();
    chk(alarm == '0, "R3 equal threshold no trip", alarm, 0);
    thr[0] = 24'd95;
    tick(1, 0, 1); tick(1, 1, 0); tick(0, 1, 0); look();
    chk(alarm == 3'b001 && $signed(step_est) == 96, "R3 one above threshold trips", $signed(step_est), 96);

    // R4 clear beats a trip at the same edge
    tick(1, 0, 1); tick(1, 1, 0); tick(0, 1, 1); look();
    chk(alarm == '0 && !trip_pulse, "R4 clear precedence", alarm, 0);

    tick(0, 0, 0); look();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++; tests++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule